// File: doc/BRIEF.md
# Three-Level Carrier PWM Modulator

This block produces the gate commands for a three-phase, three-level inverter with a clamped neutral point. Each phase has two switch pairs. The upper pair moves the phase output between the neutral level and the positive rail. The lower pair moves it between the neutral level and the negative rail. A free-running up/down counter forms one triangular carrier shared by all three phases. The carrier's frequency is fixed by a parameter and is never locked to the fundamental of the output. Its peak magnitude is the quarter-link step E. In this block's fixed-point scale, E equals the parameter `PEAK`.

At every carrier peak a sample strobe rises, and the three signed phase references are captured. The sign of each captured reference decides which switch pair of that phase is modulated. A reference at or above zero is lowered by E, and a negative reference is raised by E. The shifted value is then compared with the carrier. The pair that is not modulated is held in the state that clamps the phase to the neutral point. As a result, only one pair per phase switches within a sample period.

The carrier can be inverted. A one-cycle mode strobe captures the invert request, and the new polarity takes effect at the next carrier peak. This keeps every sample period under a single polarity.

Top module: `tlpwm_modulator`

## Requirements
- R1: The internal carrier count is a signed triangle between -PEAK and +PEAK that moves by exactly one step per clock. It is -PEAK during reset and in the first cycle after reset, and it rises from there. The `carrier` port shows this count when the polarity is normal, and the count negated when the polarity is inverted.
- R2: `sample_stb` is high in exactly those cycles where the internal count is at +PEAK or -PEAK. This includes the first cycle after reset, so one sample period is 2*PEAK cycles.
- R3: A phase reference is captured only at a clock edge where `sample_stb` is high. A change at any other time has no effect on the gates.
- R4: A mode strobe captures `inv_req` into a pending polarity. The pending polarity becomes the active polarity at the next edge where `sample_stb` is high. While the active polarity is 1, `carrier` equals the negated count.
- R5: For a captured reference r >= 0, `gate_up[i]` is registered as (r - PEAK > carrier) one cycle after the carrier value it uses. In the same case `gate_dn[i]` is 0 and `gate_dn_n[i]` is 1, which holds the lower pair at the neutral clamp.
- R6: For a captured reference r < 0, `gate_dn[i]` is registered as (r + PEAK < carrier) one cycle after the carrier value it uses. In the same case `gate_up[i]` is 0 and `gate_up_n[i]` is 1.
- R7: A captured reference of exactly zero counts as positive, and it leaves both outer switches of that phase off in every cycle.
- R8: `gate_up_n` and `gate_dn_n` are registered complements of `gate_up` and `gate_dn`. During reset all outer gates are 0 and all complements are 1.
- R9: No phase ever has `gate_up` and `gate_dn` high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | DW | Signed reference, phase a (bit index 0 of gate vectors) |
| ref_b | input | DW | Signed reference, phase b (bit index 1) |
| ref_c | input | DW | Signed reference, phase c (bit index 2) |
| mode_stb | input | 1 | One-cycle strobe that captures inv_req |
| inv_req | input | 1 | Requested carrier polarity, 1 = inverted |
| carrier | output | DW | Signed carrier after polarity |
| sample_stb | output | 1 | High in carrier peak cycles |
| gate_up | output | 3 | Upper outer switch, per phase |
| gate_up_n | output | 3 | Upper inner switch (complement) |
| gate_dn | output | 3 | Lower outer switch, per phase |
| gate_dn_n | output | 3 | Lower inner switch (complement) |

## Verification
`carrier` and `sample_stb` come straight from registers. They are therefore due in the same cycle as the count that produces them. The gates are due one edge after the carrier value they compare against. A reference or polarity captured at a peak edge shows in the gates only one edge later. The bench advances its own model at each rising edge, sampling the inputs in the same way. It compares the outputs at the following falling edge, so each result is read in the cycle its register makes it due. The random references change every cycle, which checks that changes between peaks have no effect.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;

  typedef struct packed {
    logic outer;
    logic inner;
  } pair_t;

  localparam pair_t PAIR_CLAMP = '{outer: 1'b0, inner: 1'b1};
endpackage

// File: rtl/tlpwm_carrier.sv
module tlpwm_carrier
  import tlpwm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int PEAK = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_stb,
  input  logic                 inv_req,
  output logic signed [DW-1:0] carrier,
  output logic                 sample_stb
);
  localparam logic signed [DW-1:0] PK  = PEAK[DW-1:0];
  localparam logic signed [DW-1:0] NPK = -PK;

  logic signed [DW-1:0] cnt_q, cnt_d;
  dir_e                 dir_q, dir_d;
  logic                 pend_q, pend_d;
  logic                 pol_q, pol_d;
  logic                 at_peak;

  assign at_peak = (cnt_q == PK) || (cnt_q == NPK);

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    pend_d = pend_q;
    pol_d  = pol_q;
    if (dir_q == DIR_UP) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == PK - 1'b1) dir_d = DIR_DN;
    end else begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == NPK + 1'b1) dir_d = DIR_UP;
    end
    if (mode_stb) pend_d = inv_req;
    if (at_peak)  pol_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= NPK;
      dir_q  <= DIR_UP;
      pend_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      pend_q <= pend_d;
      pol_q  <= pol_d;
    end
  end

  assign carrier    = pol_q ? -cnt_q : cnt_q;
  assign sample_stb = at_peak;

  // R1
  carrier_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= PK) && (cnt_q >= NPK));

  // R1
  carrier_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PK) |=> (cnt_q == PK - 1'b1));

  // R2
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R4
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(pol_q));
endmodule

// File: rtl/tlpwm_phase.sv
module tlpwm_phase
  import tlpwm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int PEAK = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic signed [DW-1:0] ref_in,
  input  logic signed [DW-1:0] carrier,
  output pair_t                up_pair,
  output pair_t                dn_pair
);
  localparam int XW = DW + 1;
  localparam logic signed [XW-1:0] EX = PEAK[XW-1:0];

  logic signed [DW-1:0] ref_q, ref_d;
  logic signed [XW-1:0] ref_x, car_x, shifted;
  logic                 is_pos;
  pair_t                up_q, up_d, dn_q, dn_d;

  // sign identification and shift toward zero
  always_comb begin
    ref_d   = sample_stb ? ref_in : ref_q;
    ref_x   = XW'(ref_q);
    car_x   = XW'(carrier);
    is_pos  = !ref_q[DW-1];
    shifted = is_pos ? (ref_x - EX) : (ref_x + EX);
  end

  // output control: modulate one pair, clamp the other
  always_comb begin
    up_d = PAIR_CLAMP;
    dn_d = PAIR_CLAMP;
    if (is_pos) begin
      up_d.outer = (shifted > car_x);
      up_d.inner = !(shifted > car_x);
    end else begin
      dn_d.outer = (shifted < car_x);
      dn_d.inner = !(shifted < car_x);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      up_q  <= PAIR_CLAMP;
      dn_q  <= PAIR_CLAMP;
    end else begin
      ref_q <= ref_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
    end
  end

  assign up_pair = up_q;
  assign dn_pair = dn_q;

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(ref_q));

  // R5
  pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_q[DW-1] |=> (!dn_pair.outer && dn_pair.inner));

  // R6
  neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q[DW-1] |=> (!up_pair.outer && up_pair.inner));

  // R7
  zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q == '0) |=> (!up_pair.outer && !dn_pair.outer));

  // R9
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_pair.outer && dn_pair.outer));

  // R8
  compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pair.outer != up_pair.inner) && (dn_pair.outer != dn_pair.inner));
endmodule

// File: rtl/tlpwm_modulator.sv
module tlpwm_modulator
  import tlpwm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int PEAK = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  input  logic                 mode_stb,
  input  logic                 inv_req,
  output logic signed [DW-1:0] carrier,
  output logic                 sample_stb,
  output logic [2:0]           gate_up,
  output logic [2:0]           gate_up_n,
  output logic [2:0]           gate_dn,
  output logic [2:0]           gate_dn_n
);
  localparam int NPH = 3;

  logic signed [DW-1:0] ref_arr [NPH];
  pair_t                up_arr  [NPH];
  pair_t                dn_arr  [NPH];

  assign ref_arr[0] = ref_a;
  assign ref_arr[1] = ref_b;
  assign ref_arr[2] = ref_c;

  tlpwm_carrier #(.DW(DW), .PEAK(PEAK)) u_car (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_stb   (mode_stb),
    .inv_req    (inv_req),
    .carrier    (carrier),
    .sample_stb (sample_stb)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    tlpwm_phase #(.DW(DW), .PEAK(PEAK)) u_ph (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .ref_in     (ref_arr[p]),
      .carrier    (carrier),
      .up_pair    (up_arr[p]),
      .dn_pair    (dn_arr[p])
    );
    assign gate_up[p]   = up_arr[p].outer;
    assign gate_up_n[p] = up_arr[p].inner;
    assign gate_dn[p]   = dn_arr[p].outer;
    assign gate_dn_n[p] = dn_arr[p].inner;
  end
endmodule

// File: tb/tlpwm_modulator_test.sv
module tlpwm_modulator_test;
  localparam int DW = 12;
  localparam int P  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [DW-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic mode_stb = 1'b0, inv_req = 1'b0;
  logic signed [DW-1:0] carrier;
  logic sample_stb;
  logic [2:0] gate_up, gate_up_n, gate_dn, gate_dn_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  int  n = 0;
  int  mref [3];
  bit  mpol = 0, mpend = 0;
  bit [2:0] e_up = '0, e_dn = '0;

  always #10 clk = ~clk;

  tlpwm_modulator #(.DW(DW), .PEAK(P)) uut (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .mode_stb(mode_stb), .inv_req(inv_req), .carrier(carrier),
    .sample_stb(sample_stb), .gate_up(gate_up), .gate_up_n(gate_up_n),
    .gate_dn(gate_dn), .gate_dn_n(gate_dn_n)
  );

  function automatic int tri_at(int k);
    int m;
    m = k % (4 * P);
    return (m <= 2 * P) ? (-P + m) : (3 * P - m);
  endfunction

  function automatic bit want_up(int r, int ce);
    return (r >= 0) && ((r - P) > ce);
  endfunction

  function automatic bit want_dn(int r, int ce);
    return (r < 0) && ((r + P) < ce);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n <= 0; mpol <= 0; mpend <= 0; e_up <= '0; e_dn <= '0;
      for (int i = 0; i < 3; i++) mref[i] <= 0;
    end else begin
      int c, ce;
      c  = tri_at(n);
      ce = mpol ? -c : c;
      for (int i = 0; i < 3; i++) begin
        e_up[i] <= want_up(mref[i], ce);
        e_dn[i] <= want_dn(mref[i], ce);
      end
      if (c == P || c == -P) begin
        mref[0] <= int'(ref_a); mref[1] <= int'(ref_b); mref[2] <= int'(ref_c);
        mpol <= mpend;
      end
      if (mode_stb) mpend <= inv_req;
      n <= n + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at n=%0d", req, act, exp, n);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      int c, ce;
      c  = tri_at(n);
      ce = mpol ? -c : c;
      chk(int'(carrier) == ce, "R1/R4 carrier", int'(carrier), ce);
      chk(sample_stb == (c == P || c == -P), "R2 sample_stb", int'(sample_stb), int'(c == P || c == -P));
      chk(gate_up == e_up, "R3/R5 gate_up", int'(gate_up), int'(e_up));
      chk(gate_dn == e_dn, "R3/R6 gate_dn", int'(gate_dn), int'(e_dn));
      chk((gate_up_n == ~gate_up) && (gate_dn_n == ~gate_dn), "R8 complements",
          int'({gate_up_n, gate_dn_n}), int'({~gate_up, ~gate_dn}));
      chk((gate_up & gate_dn) == 3'b000, "R9 both outer on", int'(gate_up & gate_dn), 0);
    end
  end

  task automatic rnd_cycles(int cnt, int lim);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      ref_a = DW'(int'($urandom_range(2 * lim)) - lim);
      ref_b = DW'(int'($urandom_range(2 * lim)) - lim);
      ref_c = DW'(int'($urandom_range(2 * lim)) - lim);
      mode_stb = ($urandom_range(60) == 0);
      inv_req  = $urandom_range(1) == 1;
    end
    @(negedge clk);
    mode_stb = 1'b0;
  endtask

  task automatic hold_refs(int a, int b, int c, int cyc);
    @(negedge clk);
    ref_a = DW'(a); ref_b = DW'(b); ref_c = DW'(c);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8 R1 R2 reset state
    chk(gate_up == 3'b000 && gate_dn == 3'b000, "R8 reset outer", int'({gate_up, gate_dn}), 0);
    chk(gate_up_n == 3'b111 && gate_dn_n == 3'b111, "R8 reset inner", int'({gate_up_n, gate_dn_n}), 63);
    chk(int'(carrier) == -P, "R1 reset carrier", int'(carrier), -P);
    chk(sample_stb == 1'b1, "R2 reset strobe", int'(sample_stb), 1);
    rst_n = 1'b1;

    // R7 zero references: all outer off for a full carrier period
    hold_refs(0, 0, 0, 4 * P + 4);
    for (int k = 0; k < 4 * P; k++) begin
      @(negedge clk);
      chk(gate_up == 3'b000 && gate_dn == 3'b000, "R7 zero ref", int'({gate_up, gate_dn}), 0);
    end

    // full-scale and near-boundary corners
    hold_refs(2 * P, -2 * P, 1, 4 * P + 4);
    hold_refs(-1, P, -P, 4 * P + 4);

    // R4 invert the carrier, then restore it
    @(negedge clk); inv_req = 1'b1; mode_stb = 1'b1;
    @(negedge clk); mode_stb = 1'b0; inv_req = 1'b0;
    hold_refs(P / 2, -P / 2, 3 * P / 2, 4 * P + 4);
    @(negedge clk); inv_req = 1'b0; mode_stb = 1'b1;
    @(negedge clk); mode_stb = 1'b0;
    hold_refs(P / 2, -P / 2, 3 * P / 2, 4 * P + 4);

    // R3 R5 R6 random references changing every cycle
    rnd_cycles(4000, 2 * P);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule